// File: doc/BRIEF.md
# DRAM low-power sequencer

This block is the power-management state machine of an SDRAM controller. It watches how long the controller has been idle and compares that count with a programmed timer. The programmed low-power mode then decides what happens. In clock-stop mode the memory clock is gated. In self-refresh mode the block first clears the outstanding refresh backlog, then drops CKE and issues a self-refresh command.

Leaving self-refresh follows a fixed order. The block waits until CKE has been low for a minimum time. It then brings back the clock and CKE, waits one cycle and issues a single refresh. On DDR2 devices with the DLL disabled, it also issues a mode-register load to extended mode register 1. The main scheduler reads `ready_o` to know when it may issue ordinary commands. The refresh backlog count and its urgent flag come from the controller's refresh timer. That timer lowers the count by one for each refresh strobe it sees.

Top module: `dram_lp_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, ready, memory-clock enable and CKE are high and all three command strobes are low.
- R2: With mode field 2'b01 (clock-stop) and T = clock-stop timer, idle held high and access request held low, the memory clock enable falls on the (T+1)-th consecutive such clock edge. Ready falls together with it and CKE stays high.
- R3: While the clock is stopped, an access request or the urgent-refresh flag raises clock enable and ready at the next clock edge.
- R4: If the mode field leaves 2'b01 during clock-stop, the block returns to normal operation at the next edge. It then enters the newly selected mode after that mode's idle time.
- R5: With mode field 2'b10 (self-refresh), after T+1 idle edges (T = self-refresh timer) ready falls. The block then issues one refresh strobe every second cycle until the pending count is zero. After that it issues one self-refresh strobe, in the same cycle that CKE and clock enable go low.
- R6: In self-refresh, CKE and clock enable stay low for at least T_CKE+2 cycles, counting the self-refresh strobe cycle. Exit starts once that time has passed and either an access is requested or the mode field is no longer 2'b10.
- R7: The exit runs in this order: CKE and clock enable rise at one edge, one quiet cycle follows, then one refresh strobe. Ready rises at the edge after the strobe.
- R8: When both the DDR2 flag and the DLL-disable bit are set, one mode-register strobe follows the exit refresh strobe in the next cycle, and ready rises one cycle later.
- R9: The idle count restarts from zero when idle is low, when an access is requested, or when the mode field changes.
- R10: A timer value of zero makes entry happen on the first idle edge.
- R11: Mode field values 2'b00 and 2'b11 never start low-power entry; ready and clock enable stay high.
- R12: Each command strobe is high for a single cycle, and no two strobes are high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDR clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Controller has no work queued |
| acc_req_i | input | 1 | SDRAM access requested |
| rfsh_pend_i | input | CNT_W | Outstanding refresh count |
| rfsh_urgent_i | input | 1 | Refresh backlog reached its urgent level |
| lp_mode_i | input | 2 | Low-power mode: 1 clock-stop, 2 self-refresh, other none |
| cs_tim_i | input | TMR_W | Idle cycles before clock-stop |
| sr_tim_i | input | TMR_W | Idle cycles before self-refresh |
| t_cke_i | input | TCKE_W | Minimum CKE period setting |
| dll_off_i | input | 1 | DLL-disable configuration bit |
| is_ddr2_i | input | 1 | Attached device is DDR2 |
| mclk_en_o | output | 1 | Memory clock enable |
| cke_o | output | 1 | CKE pin level |
| ref_cmd_o | output | 1 | Refresh command strobe |
| sr_cmd_o | output | 1 | Self-refresh command strobe |
| mrs_cmd_o | output | 1 | Mode-register load (EMR1) strobe |
| ready_o | output | 1 | Scheduler may issue commands |

## Verification
The bench builds the block with TMR_W=6, CNT_W=4 and TCKE_W=3. These small widths let every timer value used in the tests expire within a few cycles, including zero and short nonzero waits. A T_CKE of 3 makes the minimum-hold window longer than the time the access request waits, so the bench can show that exit is held back. A backlog of three refreshes exercises the two-cycle refresh pacing while the backlog drains, followed by one self-refresh entry that finds the backlog already empty.

// File: rtl/dram_lp_pkg.sv
package dram_lp_pkg;
  typedef enum logic [2:0] {
    S_RUN, S_CSTOP, S_DRAIN, S_SREF, S_XWAIT, S_XREF, S_XMRS
  } lp_state_e;

  localparam logic [1:0] MODE_CSTOP = 2'd1;
  localparam logic [1:0] MODE_SREF  = 2'd2;
endpackage

// File: rtl/dram_lp_idle_timer.sv
module dram_lp_idle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         count_en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  // saturating count of consecutive qualifying idle cycles
  always_ff @(posedge clk) begin
    if (rst || !count_en) cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign hit = count_en && (cnt >= limit);
endmodule

// File: rtl/dram_lp_hold_timer.sv
module dram_lp_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] t_min,
  output logic         done
);
  localparam int CW = W + 1;
  logic [CW-1:0] cnt;

  // counts cycles spent in self-refresh; one extra bit so t_min+1 fits
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt > {1'b0, t_min});
endmodule

// File: rtl/dram_lp_seq.sv
module dram_lp_seq
  import dram_lp_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int CNT_W  = 4,
  parameter int TCKE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_i,
  input  logic              acc_req_i,
  input  logic [CNT_W-1:0]  rfsh_pend_i,
  input  logic              rfsh_urgent_i,
  input  logic [1:0]        lp_mode_i,
  input  logic [TMR_W-1:0]  cs_tim_i,
  input  logic [TMR_W-1:0]  sr_tim_i,
  input  logic [TCKE_W-1:0] t_cke_i,
  input  logic              dll_off_i,
  input  logic              is_ddr2_i,
  output logic              mclk_en_o,
  output logic              cke_o,
  output logic              ref_cmd_o,
  output logic              sr_cmd_o,
  output logic              mrs_cmd_o,
  output logic              ready_o
);
  lp_state_e        state, nxt;
  logic [1:0]       mode_q;
  logic             mode_ok, cnt_en, idle_hit, hold_done;
  logic             ref_n, sr_n, mrs_n;
  logic [TMR_W-1:0] limit;

  always_ff @(posedge clk) mode_q <= lp_mode_i;

  assign mode_ok = (lp_mode_i == MODE_CSTOP) || (lp_mode_i == MODE_SREF);
  assign cnt_en  = (state == S_RUN) && idle_i && !acc_req_i &&
                   (lp_mode_i == mode_q) && mode_ok;
  assign limit   = (lp_mode_i == MODE_SREF) ? sr_tim_i : cs_tim_i;

  dram_lp_idle_timer #(.W(TMR_W)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .count_en (cnt_en),
    .limit    (limit),
    .hit      (idle_hit)
  );

  dram_lp_hold_timer #(.W(TCKE_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .run   (state == S_SREF),
    .t_min (t_cke_i),
    .done  (hold_done)
  );

  always_comb begin
    nxt   = state;
    ref_n = 1'b0;
    sr_n  = 1'b0;
    mrs_n = 1'b0;
    case (state)
      S_RUN:   if (idle_hit) nxt = (lp_mode_i == MODE_SREF) ? S_DRAIN : S_CSTOP;
      S_CSTOP: if (acc_req_i || rfsh_urgent_i || lp_mode_i != MODE_CSTOP) nxt = S_RUN;
      S_DRAIN: begin
        // one refresh per two cycles so the backlog count can follow
        if (!ref_cmd_o) begin
          if (rfsh_pend_i != '0) ref_n = 1'b1;
          else begin
            sr_n = 1'b1;
            nxt  = S_SREF;
          end
        end
      end
      S_SREF:  if (hold_done && (acc_req_i || lp_mode_i != MODE_SREF)) nxt = S_XWAIT;
      S_XWAIT: begin
        ref_n = 1'b1;
        nxt   = S_XREF;
      end
      S_XREF: begin
        if (is_ddr2_i && dll_off_i) begin
          mrs_n = 1'b1;
          nxt   = S_XMRS;
        end else nxt = S_RUN;
      end
      S_XMRS:  nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_RUN;
      ready_o   <= 1'b1;
      mclk_en_o <= 1'b1;
      cke_o     <= 1'b1;
      ref_cmd_o <= 1'b0;
      sr_cmd_o  <= 1'b0;
      mrs_cmd_o <= 1'b0;
    end else begin
      state     <= nxt;
      ready_o   <= (nxt == S_RUN);
      mclk_en_o <= !((nxt == S_CSTOP) || (nxt == S_SREF));
      cke_o     <= (nxt != S_SREF);
      ref_cmd_o <= ref_n;
      sr_cmd_o  <= sr_n;
      mrs_cmd_o <= mrs_n;
    end
  end
endmodule

// File: rtl/dram_lp_seq_chk.sv
module dram_lp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_req_i,
  input logic [1:0] lp_mode_i,
  input logic       mclk_en_o,
  input logic       cke_o,
  input logic       ref_cmd_o,
  input logic       sr_cmd_o,
  input logic       mrs_cmd_o,
  input logic       ready_o
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({ref_cmd_o, sr_cmd_o, mrs_cmd_o}) <= 1); // R12
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |=> !ref_cmd_o); // R12
  AST_SR_WITH_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_o |-> (!cke_o && !mclk_en_o)); // R5
  AST_CKE_LOW_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> !mclk_en_o); // R6
  AST_CKE_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_o) |=> !cke_o); // R6
  AST_CSTOP_WAKE: assert property (@(posedge clk) disable iff (rst)
    (!mclk_en_o && cke_o && acc_req_i) |=> mclk_en_o); // R3
  AST_NO_ENTRY_MODE: assert property (@(posedge clk) disable iff (rst)
    (ready_o && (lp_mode_i[0] == lp_mode_i[1])) |=> ready_o); // R11
  AST_MRS_AFTER_REF: assert property (@(posedge clk) disable iff (rst)
    mrs_cmd_o |-> $past(ref_cmd_o)); // R8
endmodule

bind dram_lp_seq dram_lp_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_req_i (acc_req_i),
  .lp_mode_i (lp_mode_i),
  .mclk_en_o (mclk_en_o),
  .cke_o     (cke_o),
  .ref_cmd_o (ref_cmd_o),
  .sr_cmd_o  (sr_cmd_o),
  .mrs_cmd_o (mrs_cmd_o),
  .ready_o   (ready_o)
);

// File: tb/dram_lp_seq_bench.sv
`timescale 1ns/1ps
module dram_lp_seq_bench;
  localparam int TMR_W = 6, CNT_W = 4, TCKE_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic idle = 1'b1, req = 1'b0, urg = 1'b0, dll = 1'b0, ddr2 = 1'b1;
  logic [1:0] mode = 2'd1;
  logic [TMR_W-1:0] cs_tim = 6'd3, sr_tim = 6'd2;
  logic [TCKE_W-1:0] t_cke = 3'd3;
  logic [CNT_W-1:0] pend = '0, ld_val = '0;
  logic ld = 1'b0;
  logic mclk_en, cke, ref_c, sr_c, mrs_c, ready;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_q[$];   // 1 refresh, 2 self-refresh, 3 mode-register load

  always #5 clk = ~clk;

  dram_lp_seq #(.TMR_W(TMR_W), .CNT_W(CNT_W), .TCKE_W(TCKE_W)) u_dram_lp_seq (
    .clk(clk), .rst(rst), .idle_i(idle), .acc_req_i(req), .rfsh_pend_i(pend),
    .rfsh_urgent_i(urg), .lp_mode_i(mode), .cs_tim_i(cs_tim), .sr_tim_i(sr_tim),
    .t_cke_i(t_cke), .dll_off_i(dll), .is_ddr2_i(ddr2), .mclk_en_o(mclk_en),
    .cke_o(cke), .ref_cmd_o(ref_c), .sr_cmd_o(sr_c), .mrs_cmd_o(mrs_c), .ready_o(ready));

  // refresh backlog model: each refresh strobe retires one pending refresh
  always @(posedge clk) begin
    if (ld) pend <= ld_val;
    else if (ref_c && pend != '0) pend <= pend - 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // monitor: pop expected command strobes in order (R12 one at a time)
  always @(negedge clk) begin
    if (!rst && (ref_c || sr_c || mrs_c)) begin
      int code;
      code = ref_c ? 1 : (sr_c ? 2 : 3);
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected strobe", code, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(code == e, "R5/R7/R8 strobe order", code, e);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(50_000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk(ready && mclk_en && cke && !ref_c && !sr_c && !mrs_c, "R1 reset outputs",
        {ready, mclk_en, cke, ref_c, sr_c, mrs_c}, 6'b111000);
    rst = 1'b0;

    // R2: clock-stop after cs_tim+1 idle edges
    tick(3);
    chk(mclk_en == 1'b1, "R2 clock still on after T edges", mclk_en, 1);
    tick(1);
    chk(!mclk_en && !ready && cke, "R2 clock stopped", {mclk_en, ready, cke}, 3'b001);

    // R3: wake on access request
    req = 1'b1;
    tick(1);
    chk(mclk_en && ready, "R3 wake on request", {mclk_en, ready}, 2'b11);
    req = 1'b0;
    tick(4);
    chk(!mclk_en, "R2 re-entry after request cleared", mclk_en, 0);
    urg = 1'b1;
    tick(1);
    chk(mclk_en && ready, "R3 wake on urgent refresh", {mclk_en, ready}, 2'b11);
    urg = 1'b0;

    // R9: idle gap restarts count
    tick(2);
    idle = 1'b0;
    tick(1);
    idle = 1'b1;
    tick(3);
    chk(mclk_en == 1'b1, "R9 count restarted after idle gap", mclk_en, 1);
    tick(1);
    chk(mclk_en == 1'b0, "R9 entry after full window", mclk_en, 0);

    // R4: leave clock-stop by mode change, then enter self-refresh
    mode = 2'd2;
    exp_q.push_back(2);
    tick(1);
    chk(mclk_en && ready, "R4 leave clock-stop on mode change", {mclk_en, ready}, 2'b11);
    tick(2);
    chk(ready == 1'b1, "R4 waiting self-refresh window", ready, 1);
    tick(1);
    chk(!ready && mclk_en && cke, "R5 drain state entered", {ready, mclk_en, cke}, 3'b011);
    tick(1);
    chk(sr_c && !cke && !mclk_en, "R5 self-refresh with empty backlog", {sr_c, cke, mclk_en}, 3'b100);

    // R6: request held back by minimum CKE time (t_cke=3 -> 5 low cycles)
    req = 1'b1;
    exp_q.push_back(1);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk(!cke, "R6 CKE held low during minimum time", cke, 0);
    end
    tick(1);
    chk(cke && mclk_en && !ready && !ref_c, "R7 CKE and clock back", {cke, mclk_en, ready, ref_c}, 4'b1100);
    tick(1);
    chk(ref_c && !ready, "R7 exit refresh strobe", {ref_c, ready}, 2'b10);
    tick(1);
    chk(ready && !ref_c, "R7 ready after exit refresh", {ready, ref_c}, 2'b10);
    req = 1'b0;
    idle = 1'b0;

    // R5/R10: backlog of 3 drained, timer zero
    sr_tim = '0;
    ld = 1'b1;
    ld_val = 4'd3;
    tick(1);
    ld = 1'b0;
    idle = 1'b1;
    exp_q.push_back(1); exp_q.push_back(1); exp_q.push_back(1); exp_q.push_back(2);
    tick(1);
    chk(ready == 1'b0, "R10 entry on first idle edge", ready, 1'b0);
    begin
      int n;
      n = 0;
      while (!sr_c && n < 20) begin
        tick(1);
        n++;
      end
      chk(sr_c == 1'b1, "R5 self-refresh after backlog", sr_c, 1);
      chk(n == 7, "R5 refresh pacing cycles", n, 7);
    end

    // R6/R8: exit by mode change, DDR2 with DLL off
    t_cke = '0;
    dll = 1'b1;
    mode = 2'd0;
    exp_q.push_back(1); exp_q.push_back(3);
    tick(1);
    chk(!cke, "R6 minimum hold with T_CKE=0", cke, 0);
    tick(1);
    chk(cke && mclk_en, "R6 exit on mode change", {cke, mclk_en}, 2'b11);
    tick(2);
    chk(mrs_c && !ready, "R8 mode-register strobe", {mrs_c, ready}, 2'b10);
    tick(1);
    chk(ready && !mrs_c, "R8 ready after mode-register load", {ready, mrs_c}, 2'b10);

    // R11: modes 0 and 3 never enter
    begin
      bit stay;
      stay = 1'b1;
      cs_tim = '0;
      for (int m = 0; m < 2; m++) begin
        mode = (m == 0) ? 2'd0 : 2'd3;
        for (int i = 0; i < 20; i++) begin
          tick(1);
          if (!ready || !mclk_en) stay = 1'b0;
        end
      end
      chk(stay, "R11 no entry in modes 0 and 3", stay, 1);
    end

    chk(exp_q.size() == 0, "R12 all expected strobes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule